// File: doc/BRIEF.md
# I2C Byte-Paced Bus Master

This block is a single-master I2C controller that software steers through one 8-bit control register. A write with the run bit set (while the unit enable input is high) makes it put a START condition on the bus and shift out the byte on `txByte` as the slave address, MSB first. The block then clocks the acknowledge slot and parks with SCL held low. Each later byte has to be released by software.

In that parked state, software chooses what happens next. Rewriting the run bit moves one more data byte, and its direction comes from `rxMode`. Setting the restart bit together with the run bit makes a repeated START followed by a new address byte. Setting the stop bit ends the transfer with a STOP condition. Clearing the run bit drops the bus at once. When the master receives, it drives the acknowledge level held in bit 7 during the acknowledge clock. When the master transmits, it reports the level the slave drove. Both pads are open-drain: the block only outputs pull-low enables and reads SDA back from the pad.

Each bit time is made of four equal phases of `PHASE_CYCLES` clocks. SCL is low for the first two phases and high for the last two. SDA is updated at the start of the second phase and sampled at the end of the third.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the register reads 0x00, `busy`, `waitAck` and `donePulse` are 0, and neither pad is pulled low.
- R2: The register reads back as {bit 7 = last written acknowledge level, bits 6..1 = 0, bit 0 = 1 exactly while a transfer is active}. The restart bit (bit 2) and the stop bit (bit 1) always read 0.
- R3: A write with bit 0 = 1 while idle and `unitEn` = 1 produces one START (SDA falls while SCL is high) and then sends `txByte` MSB first. The same write with `unitEn` = 0 is ignored: no bus activity, and bit 0 stays 0.
- R4: After the acknowledge slot of every byte the block enters the wait state. In that state `waitAck` = 1 and SCL is held low, and `donePulse` is high for exactly one cycle on each such entry.
- R5: In the wait state, a write of bits [2:0] = 001 with `rxMode` = 0 sends `txByte` MSB first, without any new START or STOP.
- R6: In the wait state, a write of bits [2:0] = 001 with `rxMode` = 1 releases SDA for eight clocks and then presents the received byte, MSB first, on `rxByte`. During the acknowledge clock the master drives bit 7 of the same write (0 = pull low / ACK, 1 = release / NACK).
- R7: After a transmitted byte, `slaveAck` holds the SDA level sampled in the acknowledge slot (0 = acknowledged).
- R8: In the wait state, a write of bits [2:0] = 101 produces a repeated START and then sends `txByte` as a new address byte. A write with bit 2 = 1 and bit 0 = 0 while idle has no effect.
- R9: In the wait state, a write of bits [2:0] = 011 produces a STOP (SDA rises while SCL is high). After that the block is idle with bit 0 = 0 and both pads released.
- R10: When bits [2:0] = 111 are written in the wait state, the stop request wins: the block makes a STOP and no repeated START.
- R11: A write with bit 0 = 0 while a transfer is active aborts it. On the next cycle `busy` = 0 and neither pad is pulled low.
- R12: While a byte is being shifted, SDA never changes while SCL is high. Only START and STOP conditions change SDA during SCL high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| unitEn | input | 1 | Unit enable; gates the start write |
| regWr | input | 1 | Control register write strobe |
| regWdata | input | 8 | Control register write data |
| regRdata | output | 8 | Control register read data |
| txByte | input | 8 | Byte to send (address or data) |
| rxMode | input | 1 | Direction of the next data byte (1 = master receives) |
| rxByte | output | 8 | Last byte received |
| busy | output | 1 | Transfer active |
| waitAck | output | 1 | Parked after an acknowledge slot |
| slaveAck | output | 1 | Acknowledge level seen after the last transmitted byte |
| donePulse | output | 1 | One-cycle pulse on each entry into the wait state |
| sdaIn | input | 1 | SDA pad level |
| sclDrvLow | output | 1 | Pull SCL low |
| sdaDrvLow | output | 1 | Pull SDA low |

## Verification
The bench attaches an open-drain slave model that decodes START and STOP conditions and the clocked bits. It sweeps all 256 values through both the transmit and the receive path, and varies the slave's acknowledge and the master's acknowledge level from byte to byte. A shifter wired backwards or started on the wrong phase shows up as mismatched bytes. An acknowledge taken from the wrong slot shows up as a wrong `slaveAck` or a wrong level seen by the slave.

The bench also targets the request encodings. If the restart/stop priority is reversed, the write 111 produces an extra START. If the run bit is not gated by enable, the block starts a transfer while disabled. If the abort is delayed, `busy` or a pull-low is still set one cycle after the write. If the done strobe is mis-timed, the count of pulses against the number of waits is off.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    SEG_START,
    SEG_RESTART,
    SEG_STOP,
    SEG_BYTE
  } segKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RESTART,
    ST_STOP,
    ST_XFER,
    ST_HOLD
  } ctlState_e;

  // strobes from control to the bit engine
  typedef struct packed {
    logic     load;      // begin a new segment of kind below
    logic     abort;     // drop the bus immediately
    segKind_e kind;
    logic     rxDir;     // byte segment: master receives
    logic     ackLevel;  // level driven in the ack slot when receiving
  } ctlStrobes_t;

  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        unitEn,
  input  logic        regWr,
  input  logic        wrAck,
  input  logic        wrRestart,
  input  logic        wrStop,
  input  logic        wrRun,
  input  logic        rxMode,
  input  logic        segDone,
  output ctlStrobes_t stb,
  output logic        ackLvl,
  output logic        busy,
  output logic        waitAck,
  output logic        donePulse,
  output logic        inXfer
);

  ctlState_e state, nxt;
  logic      abortReq;
  logic      enterWait;
  logic      doneQ;

  assign abortReq = regWr && !wrRun && (state != ST_IDLE);

  always_comb begin
    nxt          = state;
    stb          = '0;
    stb.kind     = SEG_BYTE;
    stb.ackLevel = ackLvl;
    enterWait    = 1'b0;
    if (abortReq) begin
      nxt       = ST_IDLE;
      stb.abort = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (regWr && wrRun && unitEn) begin
            nxt      = ST_START;
            stb.load = 1'b1;
            stb.kind = SEG_START;
          end
        end
        ST_START, ST_RESTART: begin
          if (segDone) begin
            nxt       = ST_XFER;
            stb.load  = 1'b1;
            stb.kind  = SEG_BYTE;
            stb.rxDir = 1'b0;      // address byte is always sent
          end
        end
        ST_XFER: begin
          if (segDone) begin
            nxt       = ST_HOLD;
            enterWait = 1'b1;
          end
        end
        ST_HOLD: begin
          if (regWr && wrRun) begin
            stb.load = 1'b1;
            if (wrStop) begin          // stop outranks restart
              nxt      = ST_STOP;
              stb.kind = SEG_STOP;
            end else if (wrRestart) begin
              nxt      = ST_RESTART;
              stb.kind = SEG_RESTART;
            end else begin
              nxt       = ST_XFER;
              stb.kind  = SEG_BYTE;
              stb.rxDir = rxMode;
            end
          end
        end
        ST_STOP: begin
          if (segDone) nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ackLvl <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      state <= nxt;
      doneQ <= enterWait;
      if (regWr) ackLvl <= wrAck;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign waitAck   = (state == ST_HOLD);
  assign inXfer    = (state == ST_XFER);
  assign donePulse = doneQ;

endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int unsigned PHASE_CYCLES = 125
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  input  logic [7:0]  txByte,
  input  logic        sdaIn,
  output logic        segDone,
  output logic        sclDrvLow,
  output logic        sdaDrvLow,
  output logic        ackSeen,
  output logic [7:0]  rxData
);

  localparam int unsigned CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);

  logic             active;
  segKind_e         kind;
  logic             curRx;
  logic [CNT_W-1:0] divCnt;
  logic [1:0]       phase;
  logic [3:0]       bitIdx;
  logic [7:0]       shiftReg;
  logic             sclLvl, sdaLvl;
  logic             tick, lastBit, bitLevel;
  logic [1:0]       phaseNext;

  // {scl, sda} levels for each phase of a bus condition
  function automatic logic [1:0] condLevels(input segKind_e k, input logic [1:0] p);
    unique case (k)
      SEG_START:   return p[1] ? 2'b10 : 2'b11;
      SEG_RESTART: return (p == 2'd0) ? 2'b01 : ((p == 2'd1) ? 2'b11 : 2'b10);
      SEG_STOP:    return (p == 2'd0) ? 2'b00 : ((p == 2'd1) ? 2'b10 : 2'b11);
      default:     return 2'b00;
    endcase
  endfunction

  assign tick      = active && (divCnt == CNT_LAST);
  assign lastBit   = (kind != SEG_BYTE) || (bitIdx == ACK_SLOT);
  assign segDone   = tick && (phase == 2'd3) && lastBit;
  assign phaseNext = phase + 2'd1;

  always_comb begin
    if (bitIdx == ACK_SLOT) bitLevel = curRx ? stb.ackLevel : 1'b1;
    else                    bitLevel = curRx ? 1'b1 : shiftReg[7];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      kind     <= SEG_BYTE;
      curRx    <= 1'b0;
      divCnt   <= '0;
      phase    <= '0;
      bitIdx   <= '0;
      shiftReg <= '0;
      sclLvl   <= 1'b1;
      sdaLvl   <= 1'b1;
      ackSeen  <= 1'b0;
      rxData   <= '0;
    end else if (stb.abort) begin
      active <= 1'b0;
      divCnt <= '0;
      sclLvl <= 1'b1;
      sdaLvl <= 1'b1;
    end else if (stb.load) begin
      active   <= 1'b1;
      kind     <= stb.kind;
      curRx    <= stb.rxDir;
      divCnt   <= '0;
      phase    <= '0;
      bitIdx   <= '0;
      shiftReg <= txByte;
      if (stb.kind == SEG_BYTE) sclLvl <= 1'b0;
      else {sclLvl, sdaLvl} <= condLevels(stb.kind, 2'd0);
    end else if (active) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        if ((phase == 2'd2) && (kind == SEG_BYTE)) begin
          if (bitIdx != ACK_SLOT) shiftReg <= {shiftReg[6:0], sdaIn};
          else if (curRx)         rxData   <= shiftReg;
          else                    ackSeen  <= sdaIn;
        end
        if (phase == 2'd3) begin
          if (lastBit) begin
            active <= 1'b0;
            if (kind == SEG_BYTE) sclLvl <= 1'b0;
          end else begin
            bitIdx <= bitIdx + 1'b1;
            phase  <= 2'd0;
            sclLvl <= 1'b0;
          end
        end else begin
          phase <= phaseNext;
          if (kind == SEG_BYTE) begin
            sclLvl <= phaseNext[1];
            if (phaseNext == 2'd1) sdaLvl <= bitLevel;
          end else begin
            {sclLvl, sdaLvl} <= condLevels(kind, phaseNext);
          end
        end
      end
    end
  end

  assign sclDrvLow = !sclLvl;
  assign sdaDrvLow = !sdaLvl;

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int unsigned PHASE_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       unitEn,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic [7:0] txByte,
  input  logic       rxMode,
  output logic [7:0] rxByte,
  output logic       busy,
  output logic       waitAck,
  output logic       slaveAck,
  output logic       donePulse,
  input  logic       sdaIn,
  output logic       sclDrvLow,
  output logic       sdaDrvLow
);

  ctlStrobes_t stb;
  logic        segDone;
  logic        ackLvl;
  logic        inXfer;
  logic        unusedRsvd;

  assign unusedRsvd = ^regWdata[6:3];

  i2cm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .unitEn    (unitEn),
    .regWr     (regWr),
    .wrAck     (regWdata[7]),
    .wrRestart (regWdata[2]),
    .wrStop    (regWdata[1]),
    .wrRun     (regWdata[0]),
    .rxMode    (rxMode),
    .segDone   (segDone),
    .stb       (stb),
    .ackLvl    (ackLvl),
    .busy      (busy),
    .waitAck   (waitAck),
    .donePulse (donePulse),
    .inXfer    (inXfer)
  );

  i2cm_datapath #(.PHASE_CYCLES(PHASE_CYCLES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .txByte    (txByte),
    .sdaIn     (sdaIn),
    .segDone   (segDone),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow),
    .ackSeen   (slaveAck),
    .rxData    (rxByte)
  );

  assign regRdata = {ackLvl, 6'b0, busy};

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       unitEn,
  input logic       regWr,
  input logic [7:0] regWdata,
  input logic       busy,
  input logic       waitAck,
  input logic       donePulse,
  input logic       sclDrvLow,
  input logic       sdaDrvLow,
  input logic       inXfer
);

  assert_done_in_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> waitAck);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_scl_parked_R4: assert property (@(posedge clk) disable iff (!rstN)
    waitAck |-> sclDrvLow);

  assert_abort_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regWdata[0] && busy) |=> (!busy && !sclDrvLow && !sdaDrvLow));

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regWdata[0] && !unitEn && !busy) |=> !busy);

  assert_sda_steady_R12: assert property (@(posedge clk) disable iff (!rstN)
    (inXfer && $past(inXfer) && !sclDrvLow && !$past(sclDrvLow))
      |-> (sdaDrvLow == $past(sdaDrvLow)));

endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .unitEn    (unitEn),
  .regWr     (regWr),
  .regWdata  (regWdata),
  .busy      (busy),
  .waitAck   (waitAck),
  .donePulse (donePulse),
  .sclDrvLow (sclDrvLow),
  .sdaDrvLow (sdaDrvLow),
  .inXfer    (inXfer)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       unitEn = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [7:0] txByte = 8'h00;
  logic       rxMode = 1'b0;
  logic [7:0] rxByte;
  logic       busy, waitAck, slaveAck, donePulse;
  logic       sclDrvLow, sdaDrvLow;
  logic       sclIn, sdaIn, slaveSda;

  // slave model state
  int         sBit = -1;
  logic       sRead = 1'b0;
  logic       sNack = 1'b0;
  logic [7:0] sData = 8'h00;
  logic [7:0] got = 8'h00;
  logic       mAck = 1'b1;
  int         starts = 0, stops = 0;
  int         doneCnt = 0, doubleDone = 0, expDone = 0;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  i2c_byte_master #(.PHASE_CYCLES(2)) u0 (
    .clk(clk), .rstN(rstN), .unitEn(unitEn), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .txByte(txByte), .rxMode(rxMode), .rxByte(rxByte),
    .busy(busy), .waitAck(waitAck), .slaveAck(slaveAck), .donePulse(donePulse),
    .sdaIn(sdaIn), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );

  assign slaveSda = (sBit >= 0 && sBit < 8 && sRead) ? sData[3'(7 - sBit)] :
                    (sBit == 8 && !sRead) ? sNack : 1'b1;
  assign sclIn = !sclDrvLow;
  assign sdaIn = !sdaDrvLow && slaveSda;

  // bus monitor / slave bit tracker
  initial begin
    logic pScl, pSda, pDone;
    pScl = 1'b1; pSda = 1'b1; pDone = 1'b0;
    forever begin
      @(negedge clk);
      if (pScl && sclIn) begin
        if (pSda && !sdaIn) begin starts++; sBit = -1; end
        else if (!pSda && sdaIn) begin stops++; sBit = -1; end
      end
      if (!pScl && sclIn) begin
        if (sBit >= 0 && sBit < 8) got = {got[6:0], sdaIn};
        else if (sBit == 8) mAck = sdaIn;
      end
      if (pScl && !sclIn) sBit = (sBit == 8) ? 0 : sBit + 1;
      if (donePulse) doneCnt++;
      if (donePulse && pDone) doubleDone++;
      pScl = sclIn; pSda = sdaIn; pDone = donePulse;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wrCtl(input logic [7:0] v);
    @(negedge clk);
    regWr = 1'b1; regWdata = v;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic waitHold(input string req);
    int n = 0;
    while (!waitAck && n < 4000) begin @(negedge clk); n++; end
    check(waitAck, req, 0, 1);
    expDone++;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    check(!busy, req, 1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(regRdata == 8'h00, "R1 reg", regRdata, 0);
    check(!busy && !waitAck && !donePulse, "R1 status", {busy, waitAck, donePulse}, 0);
    check(!sclDrvLow && !sdaDrvLow, "R1 pads", {sclDrvLow, sdaDrvLow}, 0);

    // R2 readback masking
    wrCtl(8'h80);
    check(regRdata == 8'h80, "R2 ack bit", regRdata, 8'h80);
    wrCtl(8'hFE);
    check(regRdata == 8'h80, "R2 reserved/write-only", regRdata, 8'h80);
    // R8 restart ignored while idle
    unitEn = 1'b1;
    wrCtl(8'h04);
    repeat (10) @(negedge clk);
    check(regRdata == 8'h00 && !busy && starts == 0, "R8 idle restart", regRdata, 0);
    // R3 start gated by enable
    unitEn = 1'b0;
    wrCtl(8'h01);
    repeat (10) @(negedge clk);
    check(regRdata == 8'h00 && !busy && starts == 0, "R3 disabled start", regRdata, 0);
    unitEn = 1'b1;

    // R3 start + address
    txByte = 8'hA4; sNack = 1'b0; sRead = 1'b0; rxMode = 1'b0;
    wrCtl(8'h01);
    check(regRdata == 8'h01, "R2 run bit", regRdata, 8'h01);
    waitHold("R4 wait after addr");
    check(starts == 1, "R3 start count", starts, 1);
    check(got == 8'hA4, "R3 address", got, 8'hA4);
    check(slaveAck == 1'b0, "R7 addr ack", slaveAck, 0);
    check(sclDrvLow, "R4 scl parked", sclDrvLow, 1);

    // R5 / R7 transmit sweep
    for (int v = 0; v < 256; v++) begin
      txByte = 8'(v); sNack = v[0];
      wrCtl(8'h01);
      waitHold("R4 wait tx");
      check(got == 8'(v), "R5 tx byte", got, v);
      check(slaveAck == v[0], "R7 slave ack", slaveAck, v[0]);
    end
    check(starts == 1 && stops == 0, "R12 no extra conditions", starts * 16 + stops, 16);

    // R8 repeated start
    sNack = 1'b0; txByte = 8'hA5;
    wrCtl(8'h05);
    waitHold("R4 wait restart");
    check(starts == 2 && stops == 0, "R8 restart", starts * 16 + stops, 32);
    check(got == 8'hA5, "R8 new address", got, 8'hA5);

    // R6 receive sweep
    rxMode = 1'b1; sRead = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic a;
      a = v[1] ^ v[4];
      sData = 8'(v);
      wrCtl({a, 7'b0000001});
      waitHold("R4 wait rx");
      check(rxByte == 8'(v), "R6 rx byte", rxByte, v);
      check(mAck == a, "R6 master ack level", mAck, a);
    end
    sRead = 1'b0; rxMode = 1'b0;

    // R10 stop outranks restart
    wrCtl(8'h07);
    waitIdle("R10 idle");
    check(stops == 1 && starts == 2, "R10 stop wins", starts * 16 + stops, 33);
    check(regRdata[0] == 1'b0, "R9 run cleared", regRdata[0], 0);

    // R9 plain stop
    txByte = 8'h3C;
    wrCtl(8'h01);
    waitHold("R4 wait addr2");
    check(got == 8'h3C, "R3 second address", got, 8'h3C);
    wrCtl(8'h03);
    waitIdle("R9 idle");
    check(stops == 2, "R9 stop count", stops, 2);
    check(!sclDrvLow && !sdaDrvLow && regRdata[0] == 1'b0, "R9 released",
          {sclDrvLow, sdaDrvLow, regRdata[0]}, 0);

    // R11 abort mid byte
    txByte = 8'h55;
    wrCtl(8'h01);
    repeat (20) @(negedge clk);
    check(busy, "R11 active before abort", busy, 1);
    wrCtl(8'h00);
    check(!busy && !sclDrvLow && !sdaDrvLow, "R11 abort mid byte",
          {busy, sclDrvLow, sdaDrvLow}, 0);

    // R11 abort while parked
    wrCtl(8'h01);
    waitHold("R4 wait before abort");
    wrCtl(8'h80);
    check(!busy && !sclDrvLow && !sdaDrvLow, "R11 abort in wait",
          {busy, sclDrvLow, sdaDrvLow}, 0);
    check(regRdata == 8'h80, "R2 readback after abort", regRdata, 8'h80);

    repeat (5) @(negedge clk);
    check(doneCnt == expDone, "R4 done pulse count", doneCnt, expDone);
    check(doubleDone == 0, "R4 done pulse width", doubleDone, 0);
    finishRun();
  end

endmodule